// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit free-running counter, advanced by a power-of-two prescaler, is shared by eight channels. Each channel holds a 16-bit value register. In compare mode it watches for the counter to equal that value and then applies a programmed action to its own output bit. In capture mode it copies the counter into the value register when a chosen edge arrives on its synchronized input pin. Either kind of event raises a sticky per-channel flag, and software clears the flag by writing a one to it.

The last channel (channel 7) is the master. On its compare event it loads any set of output bits from a data pattern, selected by a mask. It can also return the counter to zero, so the counter runs modulo its value. Software can fire any compare action at once through a force register. A bypass mode skips the prescaler and splits the counter into two 8-bit halves that each count every clock.

Control and status are reached through a flat register port. Writes are synchronous and reads are combinational.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter (address 0x08) reads 0. The control register is at 0x09, with bit0 = run, bits[3:1] = prescale code, bit4 = split, bit5 = wrap. While run is 1 and the code is 0..5, the counter steps by one every 2^code clocks. The prescaler restarts while run is 0, and writes to 0x08 are ignored.
- R2: Prescale codes 6 and 7 are reserved. With split off, the counter holds its value under either code.
- R3: With split (bit4) set and run set, the low and high bytes each step by one on every clock, whatever the prescale code. The low byte wraps without carrying into the high byte.
- R4: With wrap (bit5) set, a master-channel compare match loads the counter with 0 in place of the next count.
- R5: Register 0x0A bit n = 1 puts channel n in compare mode (0 = capture). A compare match is a counter step taken while the counter equals the channel value. It sets flag n on the next clock.
- R6: Register 0x0E holds a 2-bit action per channel at bits[2n+1:2n]: 00 none, 01 toggle, 10 drive low, 11 drive high. It is applied to cmp_o[n] on each compare event. cmp_oe_o[n] is high when the action is nonzero or master mask bit n is set.
- R7: On a master compare event, every output bit n with mask bit n set (mask at 0x0C) takes data bit n (data at 0x0D). This overrides that bit's own action in the same cycle.
- R8: Writing 1 to bit n of 0x0B applies channel n's action at that clock edge if n is in compare mode. A forced event sets no flag, and 0x0B always reads 0.
- R9: Register 0x0F holds a 2-bit edge select per channel at bits[2n+1:2n]: 00 off, 01 rising, 10 falling, 11 either. A selected edge on a capture channel copies the counter into its value and sets its flag.
- R10: Capture pins pass through two synchronizing flops. An edge applied before clock edge k sets the flag at edge k+2, and a level held for two clocks or more is always seen.
- R11: The channel value registers sit at addresses 0..7 and reset to 0x0000. Software writes take effect only while the channel is in compare mode.
- R12: Flag register 0x10 is write-one-to-clear. Zero bits leave flags unchanged, and a new event wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 8 | Capture pins, asynchronous |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| cmp_o | output | 8 | Compare output bits |
| cmp_oe_o | output | 8 | Compare output drive enables |
| flag_o | output | 8 | Per-channel event flags |

## Verification
A prescaler phase that is off by one, or a carry leaking between the split halves, shows up as a wrong counter readback. The error appears as soon as the counter is stopped and read, and a gap of tens or hundreds of ticks makes the two cases easy to tell apart. A missed or doubled compare match shows up one clock later as a wrong flag or output bit. A counter that is not cleared by the master match shows up within one wrap period as a readback above the master value. A capture synchronizer of the wrong depth shifts the flag by a whole clock, and the bench samples the flag on both sides of that clock.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam logic [4:0] A_CNT   = 5'h08;
  localparam logic [4:0] A_CTRL  = 5'h09;
  localparam logic [4:0] A_MODE  = 5'h0A;
  localparam logic [4:0] A_FORCE = 5'h0B;
  localparam logic [4:0] A_MASK  = 5'h0C;
  localparam logic [4:0] A_DATA  = 5'h0D;
  localparam logic [4:0] A_ACT   = 5'h0E;
  localparam logic [4:0] A_EDGE  = 5'h0F;
  localparam logic [4:0] A_FLAG  = 5'h10;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00, ACT_TOGGLE = 2'b01, ACT_LOW = 2'b10, ACT_HIGH = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    EDG_OFF = 2'b00, EDG_RISE = 2'b01, EDG_FALL = 2'b10, EDG_ANY = 2'b11
  } edg_e;

  typedef struct packed {
    logic       wrap;
    logic       split;
    logic [2:0] psel;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/cct_count.sv
module cct_count #(
  parameter int unsigned CW     = 16,
  parameter int unsigned MAXSEL = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [2:0]    psel_i,
  input  logic          split_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          tick_o
);
  localparam int unsigned PW = MAXSEL;
  localparam int unsigned HW = CW / 2;

  logic [PW-1:0] pc_q;
  logic [PW-1:0] pmask;
  logic          psel_ok;
  logic [CW-1:0] cnt_q;

  always_comb begin
    pmask = '0;
    for (int i = 0; i < PW; i++) pmask[i] = (i < int'(psel_i));
    psel_ok = int'(psel_i) <= MAXSEL;
    tick_o  = run_i && (split_i || (psel_ok && ((pc_q & pmask) == pmask)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (!run_i) pc_q <= '0;
    else             pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) begin
      if (clr_i)        cnt_q <= '0;
      else if (split_i) cnt_q <= {cnt_q[CW-1:HW] + 1'b1, cnt_q[HW-1:0] + 1'b1};
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cct_sync.sv
module cct_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cct_chan.sv
module cct_chan import cct_pkg::*; #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          tick_i,
  input  logic          is_cmp_i,
  input  logic [1:0]    act_i,
  input  logic [1:0]    edge_sel_i,
  input  logic          sync_i,
  input  logic          cv_we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          force_i,
  input  logic          flag_clr_i,
  input  logic          master_ev_i,
  input  logic          mask_i,
  input  logic          data_i,
  output logic [CW-1:0] cv_o,
  output logic          match_o,
  output logic          flag_o,
  output logic          out_o
);
  logic [CW-1:0] cv_q;
  logic          prev_q, flag_q, out_q;
  logic          edge_hit, cap_ev, cmp_ev, out_d;

  always_comb begin
    unique case (edg_e'(edge_sel_i))
      EDG_RISE: edge_hit = sync_i & ~prev_q;
      EDG_FALL: edge_hit = ~sync_i & prev_q;
      EDG_ANY:  edge_hit = sync_i ^ prev_q;
      default:  edge_hit = 1'b0;
    endcase
  end

  assign cap_ev  = !is_cmp_i && edge_hit;
  assign match_o = is_cmp_i && tick_i && (cnt_i == cv_q);
  assign cmp_ev  = match_o || (force_i && is_cmp_i);

  always_comb begin
    out_d = out_q;
    if (cmp_ev) begin
      unique case (act_e'(act_i))
        ACT_TOGGLE: out_d = ~out_q;
        ACT_LOW:    out_d = 1'b0;
        ACT_HIGH:   out_d = 1'b1;
        default:    out_d = out_q;
      endcase
    end
    // master pattern overrides the local action
    if (master_ev_i && mask_i) out_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cv_q   <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      prev_q <= sync_i;
      out_q  <= out_d;
      flag_q <= (flag_q & ~flag_clr_i) | match_o | cap_ev;
      if (cap_ev)                   cv_q <= cnt_i;
      else if (cv_we_i && is_cmp_i) cv_q <= wdata_i;
    end
  end

  assign cv_o   = cv_q;
  assign flag_o = flag_q;
  assign out_o  = out_q;
endmodule

// File: rtl/cc_timer.sv
module cc_timer import cct_pkg::*; #(
  parameter int unsigned NCH    = 8,
  parameter int unsigned CW     = 16,
  parameter int unsigned AW     = 5,
  parameter int unsigned MAXSEL = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cap_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           wr_i,
  input  logic [CW-1:0]  wdata_i,
  output logic [CW-1:0]  rdata_o,
  output logic [NCH-1:0] cmp_o,
  output logic [NCH-1:0] cmp_oe_o,
  output logic [NCH-1:0] flag_o
);
  localparam int unsigned CIW = $clog2(NCH);
  localparam int unsigned CTW = $bits(ctrl_t);
  localparam int unsigned MST = NCH - 1;

  ctrl_t            ctrl_q;
  logic [NCH-1:0]   mode_q, mask_q, data_q;
  logic [2*NCH-1:0] act_q, edge_q;
  logic [CW-1:0]    cnt_q;
  logic             tick, mod_clr, master_ev;
  logic [NCH-1:0]   cap_s, match, cv_we, force_p, flag_clr;
  logic [CW-1:0]    cv [NCH];

  function automatic logic hit(input logic [AW-1:0] a, input logic [4:0] ref_a);
    return wr_i && (a == AW'(ref_a));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      mask_q <= '0;
      data_q <= '0;
      act_q  <= '0;
      edge_q <= '0;
    end else begin
      if (hit(addr_i, A_CTRL)) ctrl_q <= ctrl_t'(wdata_i[CTW-1:0]);
      if (hit(addr_i, A_MODE)) mode_q <= wdata_i[NCH-1:0];
      if (hit(addr_i, A_MASK)) mask_q <= wdata_i[NCH-1:0];
      if (hit(addr_i, A_DATA)) data_q <= wdata_i[NCH-1:0];
      if (hit(addr_i, A_ACT))  act_q  <= wdata_i[2*NCH-1:0];
      if (hit(addr_i, A_EDGE)) edge_q <= wdata_i[2*NCH-1:0];
    end
  end

  assign force_p  = hit(addr_i, A_FORCE) ? wdata_i[NCH-1:0] : '0;
  assign flag_clr = hit(addr_i, A_FLAG)  ? wdata_i[NCH-1:0] : '0;

  assign master_ev = match[MST] || (force_p[MST] && mode_q[MST]);
  assign mod_clr   = ctrl_q.wrap && match[MST];

  cct_count #(.CW(CW), .MAXSEL(MAXSEL)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl_q.run),
    .psel_i  (ctrl_q.psel),
    .split_i (ctrl_q.split),
    .clr_i   (mod_clr),
    .cnt_o   (cnt_q),
    .tick_o  (tick)
  );

  cct_sync #(.W(NCH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cap_i),
    .q_o    (cap_s)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign cv_we[n]    = wr_i && (addr_i == AW'(n));
    assign cmp_oe_o[n] = (act_q[2*n+:2] != 2'b00) | mask_q[n];

    cct_chan #(.CW(CW)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cnt_i       (cnt_q),
      .tick_i      (tick),
      .is_cmp_i    (mode_q[n]),
      .act_i       (act_q[2*n+:2]),
      .edge_sel_i  (edge_q[2*n+:2]),
      .sync_i      (cap_s[n]),
      .cv_we_i     (cv_we[n]),
      .wdata_i     (wdata_i),
      .force_i     (force_p[n]),
      .flag_clr_i  (flag_clr[n]),
      .master_ev_i (master_ev),
      .mask_i      (mask_q[n]),
      .data_i      (data_q[n]),
      .cv_o        (cv[n]),
      .match_o     (match[n]),
      .flag_o      (flag_o[n]),
      .out_o       (cmp_o[n])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i < AW'(NCH)) rdata_o = cv[addr_i[CIW-1:0]];
    else if (addr_i == AW'(A_CNT))  rdata_o = cnt_q;
    else if (addr_i == AW'(A_CTRL)) rdata_o[CTW-1:0] = ctrl_q;
    else if (addr_i == AW'(A_MODE)) rdata_o[NCH-1:0] = mode_q;
    else if (addr_i == AW'(A_MASK)) rdata_o[NCH-1:0] = mask_q;
    else if (addr_i == AW'(A_DATA)) rdata_o[NCH-1:0] = data_q;
    else if (addr_i == AW'(A_ACT))  rdata_o[2*NCH-1:0] = act_q;
    else if (addr_i == AW'(A_EDGE)) rdata_o[2*NCH-1:0] = edge_q;
    else if (addr_i == AW'(A_FLAG)) rdata_o[NCH-1:0] = flag_o;
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk import cct_pkg::*; #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           run_i,
  input logic           split_i,
  input logic           wrap_i,
  input logic [2:0]     psel_i,
  input logic           tick_i,
  input logic [NCH-1:0] match_i,
  input logic [CW-1:0]  cnt_i,
  input logic [NCH-1:0] flag_i,
  input logic [AW-1:0]  addr_i,
  input logic [CW-1:0]  rdata_i
);
  localparam int unsigned HW = CW / 2;

  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !split_i && !(wrap_i && match_i[NCH-1])) |=> cnt_i == $past(cnt_i) + 1'b1);

  a_r2_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !split_i && psel_i >= 3'd6) |=> cnt_i == $past(cnt_i));

  a_r3_split_halves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && split_i && !(wrap_i && match_i[NCH-1])) |=>
      (cnt_i[HW-1:0] == $past(cnt_i[HW-1:0]) + 1'b1) &&
      (cnt_i[CW-1:HW] == $past(cnt_i[CW-1:HW]) + 1'b1));

  a_r4_wrap_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && match_i[NCH-1]) |=> cnt_i == '0);

  a_r5_flag_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i != '0) |=> (flag_i & $past(match_i)) == $past(match_i));

  a_r8_force_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AW'(A_FORCE)) |-> rdata_i == '0);
endmodule

bind cc_timer cc_timer_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (ctrl_q.run),
  .split_i (ctrl_q.split),
  .wrap_i  (ctrl_q.wrap),
  .psel_i  (ctrl_q.psel),
  .tick_i  (tick),
  .match_i (match),
  .cnt_i   (cnt_q),
  .flag_i  (flag_o),
  .addr_i  (addr_i),
  .rdata_i (rdata_o)
);

// File: tb/cc_timer_tb_top.sv
`timescale 1ns/1ps
module cc_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cap = '0;
  logic [4:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  cmp, cmp_oe, flag;
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  cc_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cap_i(cap), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .cmp_o(cmp), .cmp_oe_o(cmp_oe), .flag_o(flag)
  );

  localparam logic [4:0] CNT = 5'h08, CTRL = 5'h09, MODE = 5'h0A, FRC = 5'h0B,
                         MSK = 5'h0C, DAT = 5'h0D, ACT = 5'h0E, EDG = 5'h0F, FLG = 5'h10;

  // {write, addr, data, expected read, requirement}
  localparam int NV = 20;
  localparam logic [41:0] TBL [NV] = '{
    {1'b1, MSK,   16'h12A5, 16'h0000, 4'd7},  {1'b0, MSK,   16'h0000, 16'h00A5, 4'd7},
    {1'b1, DAT,   16'h005A, 16'h0000, 4'd7},  {1'b0, DAT,   16'h0000, 16'h005A, 4'd7},
    {1'b1, ACT,   16'hBEEF, 16'h0000, 4'd6},  {1'b0, ACT,   16'h0000, 16'hBEEF, 4'd6},
    {1'b1, EDG,   16'h1234, 16'h0000, 4'd9},  {1'b0, EDG,   16'h0000, 16'h1234, 4'd9},
    {1'b1, MODE,  16'h000F, 16'h0000, 4'd5},  {1'b0, MODE,  16'h0000, 16'h000F, 4'd5},
    {1'b1, 5'h00, 16'hCAFE, 16'h0000, 4'd11}, {1'b0, 5'h00, 16'h0000, 16'hCAFE, 4'd11},
    {1'b1, 5'h04, 16'h7777, 16'h0000, 4'd11}, {1'b0, 5'h04, 16'h0000, 16'h0000, 4'd11},
    {1'b1, CNT,   16'h5555, 16'h0000, 4'd1},  {1'b0, CNT,   16'h0000, 16'h0000, 4'd1},
    {1'b1, CTRL,  16'h003C, 16'h0000, 4'd1},  {1'b0, CTRL,  16'h0000, 16'h003C, 4'd1},
    {1'b1, FRC,   16'h00FF, 16'h0000, 4'd8},  {1'b0, FRC,   16'h0000, 16'h0000, 4'd8}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 1'b0; cap = '0; addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    logic [15:0] vmax;
    do_reset();

    // R1 / R11 / R12 reset state
    rreg(CNT, v);   check("R1 counter reset", v, 16'h0000);
    rreg(5'h00, v); check("R11 value reset", v, 16'h0000);
    rreg(FLG, v);   check("R12 flags reset", v, 16'h0000);
    check("R6 outputs reset", {cmp_oe, cmp}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][41]) wreg(TBL[i][40:36], TBL[i][35:20]);
      else begin
        rreg(TBL[i][40:36], v);
        check($sformatf("R%0d table row %0d", TBL[i][3:0], i), v, TBL[i][19:4]);
      end
    end

    // R1 divide by 4: 42 enabled edges -> 10 steps
    do_reset();
    wreg(CTRL, 16'h0005);
    repeat (40) @(negedge clk);
    wreg(CTRL, 16'h0004);
    rreg(CNT, v); check("R1 prescale div4", v, 16'd10);

    // R1 divide by 1 across 300 steps carries into high byte
    do_reset();
    wreg(CTRL, 16'h0001);
    repeat (298) @(negedge clk);
    wreg(CTRL, 16'h0000);
    rreg(CNT, v); check("R1 prescale div1", v, 16'h012C);

    // R3 split halves, reserved code ignored
    do_reset();
    wreg(CTRL, 16'h001F);
    repeat (298) @(negedge clk);
    wreg(CTRL, 16'h001E);
    rreg(CNT, v); check("R3 split halves", v, 16'h2C2C);

    // R2 reserved codes hold counter
    do_reset();
    wreg(CTRL, 16'h000D);
    repeat (20) @(negedge clk);
    rreg(CNT, v); check("R2 code 6 holds", v, 16'h0000);
    wreg(CTRL, 16'h000F);
    repeat (20) @(negedge clk);
    rreg(CNT, v); check("R2 code 7 holds", v, 16'h0000);

    // R5 R6 R8 R12 compare, actions, force
    do_reset();
    wreg(MODE, 16'h0002);
    wreg(ACT, 16'h000C);
    wreg(5'h01, 16'd20);
    rreg(5'h01, v); check("R11 write in compare mode", v, 16'd20);
    wreg(CTRL, 16'h0001);
    repeat (40) @(negedge clk);
    rreg(FLG, v); check("R5 flag on match", v, 16'h0002);
    check("R6 set action", {8'h00, cmp}, 16'h0002);
    check("R6 drive enable", {8'h00, cmp_oe}, 16'h0002);
    wreg(FLG, 16'h0001);
    rreg(FLG, v); check("R12 zero bit keeps flag", v, 16'h0002);
    wreg(FLG, 16'h0002);
    rreg(FLG, v); check("R12 one bit clears flag", v, 16'h0000);
    wreg(ACT, 16'h0004);
    wreg(FRC, 16'h0002);
    check("R8 force toggles", {8'h00, cmp}, 16'h0000);
    rreg(FLG, v); check("R8 force sets no flag", v, 16'h0000);
    rreg(FRC, v); check("R8 force reads zero", v, 16'h0000);
    wreg(ACT, 16'h0007);
    wreg(FRC, 16'h0001);
    check("R8 force ignored in capture mode", {8'h00, cmp}, 16'h0000);

    // R4 R7 wrap and master pattern
    do_reset();
    wreg(MODE, 16'h0088);
    wreg(5'h07, 16'd9);
    wreg(5'h03, 16'd9);
    wreg(MSK, 16'h000C);
    wreg(DAT, 16'h0004);
    wreg(ACT, 16'h00C0);
    wreg(CTRL, 16'h0021);
    addr = CNT;
    vmax = '0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      #1 if (rdata > vmax) vmax = rdata;
    end
    check("R4 wrap at master value", vmax, 16'd9);
    rreg(FLG, v); check("R5 flags ch3 ch7", v, 16'h0088);
    check("R7 master pattern overrides", {8'h00, cmp}, 16'h0004);
    check("R6 enable from mask", {8'h00, cmp_oe}, 16'h000C);

    // R9 R10 R11 R12 capture
    do_reset();
    wreg(CTRL, 16'h0001);
    repeat (10) @(negedge clk);
    wreg(CTRL, 16'h0000);
    rreg(CNT, v); check("R1 stopped count", v, 16'd12);
    wreg(EDG, 16'h0C90);
    @(negedge clk); cap[2] = 1'b1;
    repeat (3) @(negedge clk);
    cap[2] = 1'b0; cap[3] = 1'b1;
    repeat (5) @(negedge clk);
    rreg(FLG, v); check("R9 rising only", v, 16'h0004);
    rreg(5'h02, v); check("R9 captured value", v, 16'd12);
    cap[3] = 1'b0;
    repeat (5) @(negedge clk);
    rreg(FLG, v); check("R9 falling edge", v, 16'h000C);
    cap[4] = 1'b1;
    repeat (3) @(negedge clk);
    cap[4] = 1'b0;
    repeat (5) @(negedge clk);
    rreg(FLG, v); check("R9 edge off", v, 16'h000C);
    wreg(5'h02, 16'h1234);
    rreg(5'h02, v); check("R11 write ignored in capture", v, 16'd12);
    addr = FLG;
    cap[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1 check("R10 not yet seen", {15'd0, rdata[5]}, 16'h0000);
    @(negedge clk);
    #1 check("R10 seen after sync", {15'd0, rdata[5]}, 16'h0001);
    wreg(FLG, 16'h0004);
    rreg(FLG, v); check("R12 selective clear", v, 16'h0028);

    done = 1'b1;
    finish_run();
  end
endmodule